// File: doc/BRIEF.md
# Four-Phase FM Attenuation Envelope Generator

This block produces the attenuation envelope for every operator of a frequency-modulation voice engine. The operators share one datapath: a slot sequencer walks through all operators in turn. On each slot it reads the stored 12-bit level and the phase of one operator and forms that operator's effective rate. It decides from a per-pass counter whether the level moves on this slot, then writes the new level and phase back. The result is also sent out as a registered stream of (operator, level, phase) values for the downstream attenuator.

Each operator has four phases: rise (attack), first fall (decay), hold-fall (sustain) and let-go (release). Software writes per-operator settings: three 5-bit rates, a 4-bit release field, a 4-bit sustain field, a 7-bit total level and a 2-bit key-scale shift. It also writes a 5-bit key code for each channel and sends key-on or key-off events for single operators. The level is an attenuation, so 0 is loudest and 0xFFC is silent.

Top module: `fm_env_gen`

## Requirements
- R1: After reset every operator is in the release phase at level 0xFFC. No serviced level ever exceeds 0xFFC. Phase codes on `out_state` are attack=0, decay=1, sustain=2, release=3.
- R2: A key-on event loads level 0xFFC and the attack phase into the addressed operator. A key-off event sets the release phase and keeps the level. A key event overrides the service result of the same clock edge.
- R3: The raw rate is chosen by phase. Attack uses `cfg_ar`, decay uses `cfg_dr` and sustain uses `cfg_sr`. Release uses `{cfg_rr,1'b1}`. A raw rate of 0 gives effective rate 0. Any other raw rate gives `2*raw + (keycode >> ks)`, saturated at 63. The key code comes from the channel `op/4`.
- R4: With effective rate r and pass counter c, the shift s is `(47-r)>>2` for r<48 and 0 otherwise. An update happens only when the low s bits of c are zero. The pattern step is `(c>>s)&7`. An update whose increment is 0 leaves the level and phase unchanged.
- R5: The increment is `4 * (base << e)`. Here e = (r>>2)-12 for r>=48 and 0 otherwise, and base = row[step]. Rates below 3 give 0. Rates 3..7 use row 2 when (r&6)==6 and row 1 otherwise. Rates 8..47 use row r&3. Rates 48..63 use row 4+(r&3). The rows are 0:{0,1,0,1,0,1,0,1} 1:{0,1,0,1,1,1,0,1} 2:{0,1,1,1,0,1,1,1} 3:{0,1,1,1,1,1,1,1} 4:{1,1,1,1,1,1,1,1} 5:{1,1,1,2,1,1,1,2} 6:{1,2,1,2,1,2,1,2} 7:{1,2,2,2,1,2,2,2}, with step 0 first.
- R6: An attack update lowers level L by ceil((L+1)*inc/16). If the result is at or below the total level, the level becomes the total level and the phase becomes decay.
- R7: In attack with effective rate 63, the operator moves at once to decay at the total level. If its decay effective rate is also 63, it goes on to sustain at the sustain level. In decay with rate 63, it moves to sustain at the sustain level. A jump slot applies no increment.
- R8: A decay, sustain or release update adds the increment and clamps at 0xFFC. In decay, a result at or above the sustain level becomes the sustain level and the phase becomes sustain. Sustain and release are left only through key events.
- R9: The total level is `cfg_tl << 5` and the sustain level is `cfg_sl << 8`, both 12 bits.
- R10: One operator is serviced every SLOT_CYCLES clocks, in order 0..NUM_OPS-1. The result appears on the outputs with `out_valid` one clock after the service edge. The pass counter advances after the last operator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_we | input | 1 | Key event strobe |
| key_op | input | OP_W | Operator addressed by the key event |
| key_on | input | 1 | 1 = key-on, 0 = key-off |
| cfg_we | input | 1 | Operator settings write strobe |
| cfg_op | input | OP_W | Operator addressed by the settings write |
| cfg_ar | input | 5 | Attack rate |
| cfg_dr | input | 5 | Decay rate |
| cfg_sr | input | 5 | Sustain rate |
| cfg_rr | input | 4 | Release field |
| cfg_sl | input | 4 | Sustain level field |
| cfg_tl | input | 7 | Total level field |
| cfg_ks | input | 2 | Key-scale shift |
| kc_we | input | 1 | Key code write strobe |
| kc_ch | input | CH_W | Channel addressed by the key code write |
| kc_val | input | 5 | Channel key code |
| out_valid | output | 1 | Service result valid |
| out_op | output | OP_W | Operator just serviced |
| out_level | output | 12 | Its new attenuation |
| out_state | output | 2 | Its new phase |

## Verification
A reference model in the bench follows every serviced operator through the output stream. It is driven by random settings, key events and key codes, with attack rates kept high enough that attack, decay and sustain transitions actually happen. Random rates and key codes cover the gating shift, the pattern step and the key-scale saturation, which separates errors in rate formation from errors in the increment rows. Directed cases cover the instant attack-to-sustain chain, a saturated effective rate that jumps only to decay, and a fast release that must stop at 0xFFC. They also check the reset image seen on the first pass, so the jump, clamp and ceiling paths are told apart from ordinary stepping.

// File: rtl/eg_pkg.sv
package eg_pkg;

    localparam int          LVL_W   = 12;
    localparam logic [11:0] LVL_MAX = 12'hFFC;
    localparam int          RATE_W  = 6;
    localparam int          INC_W   = 8;

    typedef enum logic [1:0] {
        EG_ATTACK  = 2'd0,
        EG_DECAY   = 2'd1,
        EG_SUSTAIN = 2'd2,
        EG_RELEASE = 2'd3
    } eg_state_e;

    typedef struct packed {
        logic [4:0]       ar;
        logic [4:0]       dr;
        logic [4:0]       sr;
        logic [3:0]       rr;
        logic [LVL_W-1:0] tl;
        logic [LVL_W-1:0] sl;
        logic [1:0]       ks;
    } eg_cfg_t;

    // increment rows, two bits per step, step 0 in the low bits
    localparam logic [15:0] PAT_ROW [8] = '{
        16'h4444, 16'h4544, 16'h5454, 16'h5554,
        16'h5555, 16'h9595, 16'h9999, 16'hA9A9
    };

    function automatic logic [RATE_W-1:0] eff_rate(logic [4:0] raw, logic [4:0] kc, logic [1:0] ks);
        logic [6:0] sum;
        if (raw == 5'd0) return '0;
        sum = {1'b0, raw, 1'b0} + 7'(kc >> ks);
        return (sum > 7'd63) ? 6'd63 : sum[5:0];
    endfunction

    function automatic logic [3:0] div_shift(logic [RATE_W-1:0] rate);
        return (rate < 6'd48) ? 4'((6'd47 - rate) >> 2) : 4'd0;
    endfunction

    function automatic logic [INC_W-1:0] pattern_inc(logic [RATE_W-1:0] rate, logic [2:0] step);
        logic [2:0] row;
        logic [1:0] base;
        logic [1:0] ext;
        if (rate < 6'd3) return '0;
        if (rate < 6'd8)       row = ((rate & 6'd6) == 6'd6) ? 3'd2 : 3'd1;
        else if (rate < 6'd48) row = {1'b0, rate[1:0]};
        else                   row = {1'b1, rate[1:0]};
        base = PAT_ROW[row][{step, 1'b0} +: 2];
        ext  = (rate >= 6'd48) ? 2'(rate[5:2] - 4'd12) : 2'd0;
        return INC_W'(({6'b0, base} << ext) << 2);
    endfunction

endpackage

// File: rtl/eg_slot_seq.sv
module eg_slot_seq #(
    parameter int NUM_OPS     = 24,
    parameter int SLOT_CYCLES = 72,
    parameter int CNT_W       = 16,
    localparam int OP_W       = $clog2(NUM_OPS)
) (
    input  logic             clk,
    input  logic             rst,
    output logic             tick,
    output logic [OP_W-1:0]  op_idx,
    output logic [CNT_W-1:0] pass_cnt
);
    generate
        if (SLOT_CYCLES <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int PS_W = $clog2(SLOT_CYCLES);
            logic [PS_W-1:0] ps_q;
            always_ff @(posedge clk) begin
                if (rst)
                    ps_q <= '0;
                else if (ps_q == PS_W'(SLOT_CYCLES - 1))
                    ps_q <= '0;
                else
                    ps_q <= ps_q + 1'b1;
            end
            assign tick = (ps_q == PS_W'(SLOT_CYCLES - 1));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            op_idx   <= '0;
            pass_cnt <= '0;
        end else if (tick) begin
            if (op_idx == OP_W'(NUM_OPS - 1)) begin
                op_idx   <= '0;
                pass_cnt <= pass_cnt + 1'b1;
            end else begin
                op_idx <= op_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/eg_rate_sel.sv
module eg_rate_sel
    import eg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  eg_state_e          state,
    input  eg_cfg_t            cfg,
    input  logic [4:0]         kc,
    input  logic [CNT_W-1:0]   pass_cnt,
    output logic [RATE_W-1:0]  rate,
    output logic [RATE_W-1:0]  dr_rate,
    output logic               upd,
    output logic [INC_W-1:0]   inc
);
    logic [4:0]       raw;
    logic [3:0]       sh;
    logic [CNT_W-1:0] mask;
    logic [2:0]       step;

    always_comb begin
        unique case (state)
            EG_ATTACK:  raw = cfg.ar;
            EG_DECAY:   raw = cfg.dr;
            EG_SUSTAIN: raw = cfg.sr;
            default:    raw = {cfg.rr, 1'b1};
        endcase
        rate    = eff_rate(raw, kc, cfg.ks);
        dr_rate = eff_rate(cfg.dr, kc, cfg.ks);
        sh      = div_shift(rate);
        mask    = (CNT_W'(1) << sh) - CNT_W'(1);
        step    = 3'((pass_cnt >> sh) & CNT_W'(7));
        inc     = pattern_inc(rate, step);
        upd     = ((pass_cnt & mask) == '0) && (inc != '0);
    end
endmodule

// File: rtl/eg_level_step.sv
module eg_level_step
    import eg_pkg::*;
(
    input  eg_state_e         state,
    input  logic [LVL_W-1:0]  level,
    input  logic [LVL_W-1:0]  tl,
    input  logic [LVL_W-1:0]  sl,
    input  logic [RATE_W-1:0] rate,
    input  logic [RATE_W-1:0] dr_rate,
    input  logic              upd,
    input  logic [INC_W-1:0]  inc,
    output logic [LVL_W-1:0]  nxt_level,
    output eg_state_e         nxt_state
);
    logic [18:0]        prod;
    logic [14:0]        dec;
    logic signed [15:0] diff;
    logic [12:0]        sum;

    always_comb begin
        nxt_level = level;
        nxt_state = state;
        prod = (19'(level) + 19'd1) * 19'(inc);
        dec  = 15'((prod + 19'd15) >> 4);
        diff = $signed({4'b0, level}) - $signed({1'b0, dec});
        sum  = 13'(level) + 13'(inc);
        if (state == EG_ATTACK && rate == 6'd63) begin
            nxt_level = tl;
            nxt_state = EG_DECAY;
            if (dr_rate == 6'd63) begin
                nxt_level = sl;
                nxt_state = EG_SUSTAIN;
            end
        end else if (state == EG_DECAY && rate == 6'd63) begin
            nxt_level = sl;
            nxt_state = EG_SUSTAIN;
        end else if (upd) begin
            if (state == EG_ATTACK) begin
                if (diff <= $signed({4'b0, tl})) begin
                    nxt_level = tl;
                    nxt_state = EG_DECAY;
                end else begin
                    nxt_level = diff[LVL_W-1:0];
                end
            end else begin
                nxt_level = (sum > 13'(LVL_MAX)) ? LVL_MAX : sum[LVL_W-1:0];
                if (state == EG_DECAY && nxt_level >= sl) begin
                    nxt_level = sl;
                    nxt_state = EG_SUSTAIN;
                end
            end
        end
    end
endmodule

// File: rtl/fm_env_gen.sv
module fm_env_gen
    import eg_pkg::*;
#(
    parameter int NUM_CH      = 6,
    parameter int OPS_PER_CH  = 4,
    parameter int SLOT_CYCLES = 72,
    parameter int CNT_W       = 16,
    localparam int NUM_OPS    = NUM_CH * OPS_PER_CH,
    localparam int OP_W       = $clog2(NUM_OPS),
    localparam int CH_W       = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             key_we,
    input  logic [OP_W-1:0]  key_op,
    input  logic             key_on,
    input  logic             cfg_we,
    input  logic [OP_W-1:0]  cfg_op,
    input  logic [4:0]       cfg_ar,
    input  logic [4:0]       cfg_dr,
    input  logic [4:0]       cfg_sr,
    input  logic [3:0]       cfg_rr,
    input  logic [3:0]       cfg_sl,
    input  logic [6:0]       cfg_tl,
    input  logic [1:0]       cfg_ks,
    input  logic             kc_we,
    input  logic [CH_W-1:0]  kc_ch,
    input  logic [4:0]       kc_val,
    output logic             out_valid,
    output logic [OP_W-1:0]  out_op,
    output logic [11:0]      out_level,
    output logic [1:0]       out_state
);
    logic [LVL_W-1:0] lvl_q [NUM_OPS];
    eg_state_e        st_q  [NUM_OPS];
    eg_cfg_t          cfg_q [NUM_OPS];
    logic [4:0]       kc_q  [NUM_CH];

    logic             slot_tick;
    logic [OP_W-1:0]  svc_op;
    logic [CNT_W-1:0] pass_cnt;
    logic [CH_W-1:0]  svc_ch;
    eg_state_e        svc_st, nxt_st;
    logic [LVL_W-1:0] svc_lvl, nxt_lvl;
    eg_cfg_t          svc_cfg;
    logic [RATE_W-1:0] svc_rate, svc_dr_rate;
    logic             svc_upd;
    logic [INC_W-1:0] svc_inc;

    eg_slot_seq #(.NUM_OPS(NUM_OPS), .SLOT_CYCLES(SLOT_CYCLES), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .tick(slot_tick), .op_idx(svc_op), .pass_cnt(pass_cnt)
    );

    assign svc_ch  = CH_W'(svc_op / OP_W'(OPS_PER_CH));
    assign svc_st  = st_q[svc_op];
    assign svc_lvl = lvl_q[svc_op];
    assign svc_cfg = cfg_q[svc_op];

    eg_rate_sel #(.CNT_W(CNT_W)) u_rate (
        .state(svc_st), .cfg(svc_cfg), .kc(kc_q[svc_ch]), .pass_cnt(pass_cnt),
        .rate(svc_rate), .dr_rate(svc_dr_rate), .upd(svc_upd), .inc(svc_inc)
    );

    eg_level_step u_step (
        .state(svc_st), .level(svc_lvl), .tl(svc_cfg.tl), .sl(svc_cfg.sl),
        .rate(svc_rate), .dr_rate(svc_dr_rate), .upd(svc_upd), .inc(svc_inc),
        .nxt_level(nxt_lvl), .nxt_state(nxt_st)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_OPS; i++) begin
                lvl_q[i] <= LVL_MAX;
                st_q[i]  <= EG_RELEASE;
                cfg_q[i] <= '0;
            end
            for (int c = 0; c < NUM_CH; c++) kc_q[c] <= '0;
            out_valid <= 1'b0;
            out_op    <= '0;
            out_level <= LVL_MAX;
            out_state <= EG_RELEASE;
        end else begin
            out_valid <= slot_tick;
            if (slot_tick) begin
                lvl_q[svc_op] <= nxt_lvl;
                st_q[svc_op]  <= nxt_st;
                out_op        <= svc_op;
                out_level     <= nxt_lvl;
                out_state     <= nxt_st;
            end
            if (cfg_we && cfg_op < OP_W'(NUM_OPS))
                cfg_q[cfg_op] <= '{ar: cfg_ar, dr: cfg_dr, sr: cfg_sr, rr: cfg_rr,
                                   tl: {cfg_tl, 5'b0}, sl: {cfg_sl, 8'b0}, ks: cfg_ks};
            if (kc_we && kc_ch < CH_W'(NUM_CH))
                kc_q[kc_ch] <= kc_val;
            if (key_we && key_op < OP_W'(NUM_OPS)) begin
                st_q[key_op] <= key_on ? EG_ATTACK : EG_RELEASE;
                if (key_on) lvl_q[key_op] <= LVL_MAX;
            end
        end
    end
endmodule

// File: rtl/eg_checker.sv
module eg_checker #(
    parameter int NUM_OPS = 24,
    parameter int OP_W    = 5
) (
    input logic            clk,
    input logic            rst,
    input logic            tick,
    input logic [1:0]      svc_state,
    input logic [5:0]      svc_rate,
    input logic [11:0]     svc_level,
    input logic            out_valid,
    input logic [OP_W-1:0] out_op,
    input logic [11:0]     out_level,
    input logic [1:0]      out_state
);
    logic [OP_W-1:0] exp_op_q;

    always_ff @(posedge clk) begin
        if (rst)
            exp_op_q <= '0;
        else if (out_valid)
            exp_op_q <= (exp_op_q == OP_W'(NUM_OPS - 1)) ? '0 : exp_op_q + 1'b1;
    end

    AST_LEVEL_CEIL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_level <= 12'hFFC); // R1

    AST_ROUND_ROBIN: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_op == exp_op_q); // R10

    AST_ZERO_RATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        tick && svc_rate == 6'd0 |=> out_level == $past(svc_level)); // R3

    AST_INSTANT_ATTACK: assert property (@(posedge clk) disable iff (rst)
        tick && svc_state == 2'd0 && svc_rate == 6'd63 |=> out_valid && out_state != 2'd0); // R7

    AST_HOLD_PHASE: assert property (@(posedge clk) disable iff (rst)
        tick && svc_state[1] |=> out_state == $past(svc_state)); // R8
endmodule

bind fm_env_gen eg_checker #(.NUM_OPS(NUM_OPS), .OP_W(OP_W)) u_chk (
    .clk(clk), .rst(rst), .tick(slot_tick), .svc_state(svc_st), .svc_rate(svc_rate),
    .svc_level(svc_lvl), .out_valid(out_valid), .out_op(out_op),
    .out_level(out_level), .out_state(out_state)
);

// File: tb/fm_env_gen_tb.sv
module fm_env_gen_tb;
    localparam int NCH = 6;
    localparam int NOP = 24;
    localparam int SLOT = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic key_we = 0, key_on = 0, cfg_we = 0, kc_we = 0;
    logic [4:0] key_op = 0, cfg_op = 0, cfg_ar = 0, cfg_dr = 0, cfg_sr = 0, kc_val = 0;
    logic [3:0] cfg_rr = 0, cfg_sl = 0;
    logic [6:0] cfg_tl = 0;
    logic [1:0] cfg_ks = 0;
    logic [2:0] kc_ch = 0;
    logic       out_valid;
    logic [4:0] out_op;
    logic [11:0] out_level;
    logic [1:0] out_state;

    always #4 clk = ~clk;

    fm_env_gen #(.NUM_CH(NCH), .OPS_PER_CH(4), .SLOT_CYCLES(SLOT), .CNT_W(16)) u_dut (
        .clk(clk), .rst(rst), .key_we(key_we), .key_op(key_op), .key_on(key_on),
        .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_ar(cfg_ar), .cfg_dr(cfg_dr), .cfg_sr(cfg_sr),
        .cfg_rr(cfg_rr), .cfg_sl(cfg_sl), .cfg_tl(cfg_tl), .cfg_ks(cfg_ks),
        .kc_we(kc_we), .kc_ch(kc_ch), .kc_val(kc_val),
        .out_valid(out_valid), .out_op(out_op), .out_level(out_level), .out_state(out_state)
    );

    int n_chk = 0, n_fail = 0;

    // increment rows of R5
    int PAT [64] = '{0,1,0,1,0,1,0,1, 0,1,0,1,1,1,0,1, 0,1,1,1,0,1,1,1, 0,1,1,1,1,1,1,1,
                     1,1,1,1,1,1,1,1, 1,1,1,2,1,1,1,2, 1,2,1,2,1,2,1,2, 1,2,2,2,1,2,2,2};

    // reference model state
    int m_lvl [NOP], m_st [NOP];
    int m_ar [NOP], m_dr [NOP], m_sr [NOP], m_rr [NOP], m_sl [NOP], m_tl [NOP], m_ks [NOP];
    int m_kc [NCH];
    int m_pass, m_exp_op, last_valid_cyc, cyc;
    int obs_lvl [NOP], obs_st [NOP];

    // inputs seen at the last edge
    logic p_key_we, p_key_on, p_cfg_we, p_kc_we;
    logic [4:0] p_key_op, p_cfg_op, p_ar, p_dr, p_sr, p_kc_val;
    logic [3:0] p_rr, p_sl;
    logic [6:0] p_tl;
    logic [1:0] p_ks;
    logic [2:0] p_kc_ch;

    function automatic int eff(int raw, int kc, int ks);
        int s;
        if (raw == 0) return 0;
        s = 2 * raw + (kc >> ks);
        return (s > 63) ? 63 : s;
    endfunction

    function automatic int inc_of(int r, int step);
        int row, e;
        if (r < 3) return 0;
        if (r < 8) row = ((r & 6) == 6) ? 2 : 1;
        else if (r < 48) row = r & 3;
        else row = 4 + (r & 3);
        e = (r >= 48) ? (r >> 2) - 12 : 0;
        return (PAT[row * 8 + step] << e) * 4;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NOP; i++) begin
            m_lvl[i] = 12'hFFC; m_st[i] = 3;
            m_ar[i] = 0; m_dr[i] = 0; m_sr[i] = 0; m_rr[i] = 0;
            m_sl[i] = 0; m_tl[i] = 0; m_ks[i] = 0;
            obs_lvl[i] = 12'hFFC; obs_st[i] = 3;
        end
        for (int c = 0; c < NCH; c++) m_kc[c] = 0;
        m_pass = 0; m_exp_op = 0; last_valid_cyc = -1;
    endtask

    // one service of operator op (R3 R4 R5 R6 R7 R8 R9)
    task automatic model_service(input int op, output string tag);
        int raw, r, dr, kc, sh, step, inc, n, lvl, st, tl, sl;
        kc = m_kc[op / 4]; lvl = m_lvl[op]; st = m_st[op];
        tl = m_tl[op] << 5; sl = m_sl[op] << 8;
        case (st)
            0: raw = m_ar[op];
            1: raw = m_dr[op];
            2: raw = m_sr[op];
            default: raw = (m_rr[op] << 1) | 1;
        endcase
        r  = eff(raw, kc, m_ks[op]);
        dr = eff(m_dr[op], kc, m_ks[op]);
        tag = "R8 (rate R3 gate R4 pattern R5 levels R9)";
        if (st == 0 && r == 63) begin
            tag = "R7 attack jump";
            lvl = tl; st = 1;
            if (dr == 63) begin lvl = sl; st = 2; end
        end else if (st == 1 && r == 63) begin
            tag = "R7 decay jump";
            lvl = sl; st = 2;
        end else begin
            sh = (r < 48) ? (47 - r) >> 2 : 0;
            step = (m_pass >> sh) & 7;
            inc = inc_of(r, step);
            if ((m_pass & ((1 << sh) - 1)) == 0 && inc != 0) begin
                if (st == 0) begin
                    tag = "R6 attack step";
                    n = lvl - (((lvl + 1) * inc + 15) / 16);
                    if (n <= tl) begin lvl = tl; st = 1; end
                    else lvl = n;
                end else begin
                    n = lvl + inc;
                    if (n > 12'hFFC) n = 12'hFFC;
                    if (st == 1 && n >= sl) begin n = sl; st = 2; end
                    lvl = n;
                end
            end
        end
        if (m_pass == 0) tag = {tag, " R1 reset image"};
        m_lvl[op] = lvl; m_st[op] = st;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        p_key_we <= key_we; p_key_on <= key_on; p_key_op <= key_op;
        p_cfg_we <= cfg_we; p_cfg_op <= cfg_op; p_ar <= cfg_ar; p_dr <= cfg_dr; p_sr <= cfg_sr;
        p_rr <= cfg_rr; p_sl <= cfg_sl; p_tl <= cfg_tl; p_ks <= cfg_ks;
        p_kc_we <= kc_we; p_kc_ch <= kc_ch; p_kc_val <= kc_val;
    end

    always @(negedge clk) begin
        string tag;
        if (rst) begin
            model_reset();
        end else begin
            if (out_valid) begin
                check(out_op == 5'(m_exp_op), "R10 service order", int'(out_op), m_exp_op);
                if (last_valid_cyc >= 0)
                    check(cyc - last_valid_cyc == SLOT, "R10 slot spacing", cyc - last_valid_cyc, SLOT);
                last_valid_cyc = cyc;
                model_service(m_exp_op, tag);
                check(int'(out_level) == m_lvl[m_exp_op] && int'(out_state) == m_st[m_exp_op],
                      tag, {out_state, 2'b0, out_level}, (m_st[m_exp_op] << 14) | m_lvl[m_exp_op]);
                obs_lvl[m_exp_op] = out_level; obs_st[m_exp_op] = out_state;
                if (m_exp_op == NOP - 1) begin
                    m_exp_op = 0; m_pass = (m_pass + 1) & 16'hFFFF;
                end else m_exp_op++;
            end
            // writes of the same edge take effect after the service (R2)
            if (p_cfg_we) begin
                m_ar[p_cfg_op] = p_ar; m_dr[p_cfg_op] = p_dr; m_sr[p_cfg_op] = p_sr;
                m_rr[p_cfg_op] = p_rr; m_sl[p_cfg_op] = p_sl; m_tl[p_cfg_op] = p_tl;
                m_ks[p_cfg_op] = p_ks;
            end
            if (p_kc_we && p_kc_ch < NCH) m_kc[p_kc_ch] = p_kc_val;
            if (p_key_we) begin
                m_st[p_key_op] = p_key_on ? 0 : 3;
                if (p_key_on) m_lvl[p_key_op] = 12'hFFC;
            end
        end
    end

    task automatic do_cfg(input int op, ar, dr, sr, rr, sl, tl, ks);
        @(negedge clk);
        cfg_op = 5'(op); cfg_ar = 5'(ar); cfg_dr = 5'(dr); cfg_sr = 5'(sr);
        cfg_rr = 4'(rr); cfg_sl = 4'(sl); cfg_tl = 7'(tl); cfg_ks = 2'(ks); cfg_we = 1;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic do_kc(input int ch, input int v);
        @(negedge clk);
        kc_ch = 3'(ch); kc_val = 5'(v); kc_we = 1;
        @(negedge clk);
        kc_we = 0;
    endtask

    task automatic do_key(input int op, input bit on);
        @(negedge clk);
        key_op = 5'(op); key_on = on; key_we = 1;
        @(negedge clk);
        key_we = 0;
    endtask

    task automatic wait_passes(input int n);
        repeat (n * NOP * SLOT) @(negedge clk);
    endtask

    initial begin
        int seed;
        seed = 32'h5EED_0123;
        void'($urandom(seed));
        cyc = 0;
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R1 no output in reset", out_valid, 0);
        rst = 0;
        wait_passes(1);
        for (int i = 0; i < NOP; i++)
            check(obs_lvl[i] == 12'hFFC && obs_st[i] == 3, "R1 reset image", obs_lvl[i], 12'hFFC);

        // R7: attack and decay both at rate 63 -> sustain at SL (R9: field 2 -> 0x200)
        do_kc(0, 31);
        do_cfg(0, 31, 31, 0, 0, 2, 3, 0);
        do_key(0, 1);
        wait_passes(2);
        check(obs_st[0] == 2 && obs_lvl[0] == 12'h200, "R7 chained jump", obs_lvl[0], 12'h200);

        // R3 saturation 31*2+(31>>3) -> 63, decay rate 0 -> hold at TL (R9: 5<<5)
        do_kc(1, 31);
        do_cfg(4, 31, 0, 0, 15, 0, 5, 3);
        do_key(4, 1);
        wait_passes(2);
        check(obs_st[4] == 1 && obs_lvl[4] == 12'h0A0, "R7 jump to decay at TL", obs_lvl[4], 12'h0A0);

        // R8 fast release stops at the ceiling
        do_key(4, 0);
        wait_passes(200);
        check(obs_st[4] == 3 && obs_lvl[4] == 12'hFFC, "R8 release ceiling", obs_lvl[4], 12'hFFC);

        // R2 key-off keeps the level
        do_key(0, 0);
        wait_passes(1);
        check(obs_st[0] == 3, "R2 key-off phase", obs_st[0], 3);

        // R6 ordinary attack with modest rate
        do_kc(2, 10);
        do_cfg(8, 20, 12, 6, 7, 8, 16, 1);
        do_key(8, 1);
        wait_passes(60);
        check(obs_st[8] != 0, "R6 attack completes", obs_st[8], 1);

        // constrained random mix; every output checked by the model
        for (int it = 0; it < 1500; it++) begin
            int k;
            k = $urandom_range(0, 9);
            if (k < 4)
                do_cfg($urandom_range(0, NOP - 1), $urandom_range(8, 31), $urandom_range(0, 31),
                       $urandom_range(0, 31), $urandom_range(0, 15), $urandom_range(0, 15),
                       $urandom_range(0, 127), $urandom_range(0, 3));
            else if (k < 5)
                do_kc($urandom_range(0, NCH - 1), $urandom_range(0, 31));
            else
                do_key($urandom_range(0, NOP - 1), ($urandom_range(0, 2) != 0));
            repeat ($urandom_range(0, 12)) @(negedge clk);
        end
        wait_passes(2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (199000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule